// File: doc/BRIEF.md
# Polled Console Character Port

This peripheral gives software a console receiver and transmitter as four word registers in a fixed window at the top of the address space. Software loops on a ready flag in bit 0 of a status word. When the flag is set, it reads a received byte or writes a byte to send. Reads and writes are single-cycle strobes on a simple bus. Read data is combinational from the address. Any side effect of a read or write takes place at the clock edge that ends the strobe.

On the console side, each received byte arrives as a one-cycle strobe with its data. The receive side never stalls the console, so a byte that arrives while the holding register is still full is lost, and a sticky flag records the loss. Each transmitted byte is offered with a valid/ready handshake and held steady until the console takes it. Each direction buffers exactly one byte.

Register map, relative to `BASE` (default 0xFFFF0000):

- +0x0: receive status.
- +0x4: receive data.
- +0x8: transmit status.
- +0xC: transmit data.

Top module: `console_port`

## Requirements
- R1: After reset the receive status reads 0, the transmit status reads 1, and `tx_valid` is low.
- R2: A byte strobed in on `rx_valid` sets bit 0 of the receive status word at `BASE`+0x0. All other bits of that word read zero, except bit 1, which is the overrun flag.
- R3: A read of `BASE`+0x4 returns the held byte zero-extended to 32 bits. The same read clears receive status bit 0 at the end of the cycle.
- R4: Bit 0 of the transmit status word at `BASE`+0x8 reads 1 when a byte may be written and 0 while a byte is pending. All other bits read zero.
- R5: A write to `BASE`+0xC loads `wdata[7:0]`, raises `tx_valid` with that byte on `tx_byte`, and clears transmit status bit 0. The byte is released, and `tx_valid` drops, at the first clock edge where `tx_ready` is high.
- R6: While a transmit byte is pending, `tx_byte` holds steady, and a write to `BASE`+0xC that is not accompanied by `tx_ready` is ignored.
- R7: A byte that arrives while the receiver is full is dropped, and the held byte is kept. The arrival sets receive status bit 1, which stays set until the receive status word is read. That read still returns the 1.
- R8: If a byte arrives in the same cycle as a read of the receive data register, the read returns the old byte and the new byte is held. Receive status bit 0 stays at 1 and no overrun is flagged.
- R9: If a write to the transmit data register coincides with the console accepting the pending byte, the new byte becomes pending at once and `tx_valid` stays high.
- R10: The following are ignored and do not change any state:
  - writes to either status register;
  - reads and writes at addresses outside the four words, including misaligned addresses.
  
  These undecoded reads, and reads of the transmit data register, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| rx_valid | input | 1 | One-cycle strobe: received byte present |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte pending |
| tx_byte | output | 8 | Transmit byte |
| tx_ready | input | 1 | Console takes the pending byte |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both.

- **Receive side:** a console arrival coincides with the software read of the receive data register. The bench raises the arrival strobe in the same cycle as the read. It then judges three things: the read returned the old byte, the new byte is held afterwards, and the overrun flag stays clear.
- **Transmit side:** the console handshake coincides with a new write. The bench drives `tx_ready` together with the write strobe. It then checks that `tx_valid` never drops and that the new byte is on `tx_byte`.

All 256 byte values are swept through both directions, with expected values taken from the loop index.

// File: rtl/console_port.sv
module console_port #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready
);
  localparam logic [1:0] SEL_RXS = 2'd0;
  localparam logic [1:0] SEL_RXD = 2'd1;
  localparam logic [1:0] SEL_TXS = 2'd2;
  localparam logic [1:0] SEL_TXD = 2'd3;

  logic       rx_full, rx_ovr, tx_full;
  logic [7:0] rx_hold;

  wire       hit    = (bus_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) && (bus_addr[1:0] == 2'b00);
  wire [1:0] sel    = bus_addr[3:2];
  wire       rd_rxs = bus_rd & hit & (sel == SEL_RXS);
  wire       rd_rxd = bus_rd & hit & (sel == SEL_RXD);
  wire       wr_txd = bus_wr & hit & (sel == SEL_TXD);
  wire       tx_take = tx_full & tx_ready;
  wire       rx_load = rx_valid & (~rx_full | rd_rxd);
  wire       rx_lost = rx_valid & rx_full & ~rd_rxd;
  wire       tx_load = wr_txd & (~tx_full | tx_take);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
      rx_hold <= '0;
    end else begin
      if (rx_load) begin
        rx_full <= 1'b1;
        rx_hold <= rx_byte;
      end else if (rd_rxd) begin
        rx_full <= 1'b0;
      end
      if (rx_lost)     rx_ovr <= 1'b1;
      else if (rd_rxs) rx_ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_byte <= '0;
    end else if (tx_load) begin
      tx_full <= 1'b1;
      tx_byte <= bus_wdata[7:0];
    end else if (tx_take) begin
      tx_full <= 1'b0;
    end
  end

  assign tx_valid = tx_full;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && hit) begin
      case (sel)
        SEL_RXS: bus_rdata = {30'd0, rx_ovr, rx_full};
        SEL_RXD: bus_rdata = {24'd0, rx_hold};
        SEL_TXS: bus_rdata = {31'd0, ~tx_full};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module console_port_chk #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [31:0]       bus_rdata,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic [7:0]        tx_byte,
  input logic              tx_ready,
  input logic              rx_full,
  input logic              rx_ovr
);
  wire in_win = (bus_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) && (bus_addr[1:0] == 2'b00);
  wire rd_rxd = bus_rd && in_win && (bus_addr[3:2] == 2'd1);

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !rx_valid) |=> !rx_full);

  a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  a_r5_tx_release: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !bus_wr) |=> !tx_valid);

  a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !rd_rxd) |=> rx_ovr);

  a_r8_arrive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rd_rxd && !rx_ovr) |=> (rx_full && !rx_ovr));

  a_r10_quiet_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !in_win) |-> (bus_rdata == 32'd0));
endmodule

bind console_port console_port_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .rx_valid(rx_valid), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .tx_ready(tx_ready), .rx_full(rx_full), .rx_ovr(rx_ovr)
);

// File: tb/test_console_port.sv
`timescale 1ns/1ps
module test_console_port;
  localparam logic [31:0] RXS = 32'hFFFF_0000;
  localparam logic [31:0] RXD = 32'hFFFF_0004;
  localparam logic [31:0] TXS = 32'hFFFF_0008;
  localparam logic [31:0] TXD = 32'hFFFF_000C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic tx_valid;
  logic [7:0] tx_byte;
  logic tx_ready = 1'b0;
  int checks = 0, fails = 0;
  logic [31:0] d;

  always #2.5 clk = ~clk;

  console_port i_console_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] q);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 q = bus_rdata;
    @(posedge clk); #0.5;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(posedge clk); #0.5;
    bus_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #0.5;
    rx_valid = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk);
    tx_ready = 1'b1;
    @(posedge clk); #0.5;
    tx_ready = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    // R1 reset state
    rd(RXS, d); chk("R1 rx status", d, 0);
    rd(TXS, d); chk("R1 tx status", d, 1);
    #1 chk("R1 tx_valid", {31'd0, tx_valid}, 0);

    // R2 R3 sweep every receive byte
    for (int b = 0; b < 256; b++) begin
      push(8'(b));
      rd(RXS, d); chk("R2 rx ready", d, 1);
      rd(RXD, d); chk("R3 rx data", d, 32'(b));
      rd(RXS, d); chk("R3 rx cleared", d, 0);
    end

    // R4 R5 sweep every transmit byte
    for (int b = 0; b < 256; b++) begin
      wr(TXD, 32'hABCD_EF00 | 32'(b));
      #1 chk("R5 tx_valid", {31'd0, tx_valid}, 1);
      chk("R5 tx_byte", {24'd0, tx_byte}, 32'(b));
      rd(TXS, d); chk("R4 tx busy", d, 0);
      accept();
      #1 chk("R5 released", {31'd0, tx_valid}, 0);
      rd(TXS, d); chk("R4 tx free", d, 1);
    end

    // R6 write while pending is ignored
    wr(TXD, 32'h5A);
    wr(TXD, 32'hA5);
    #1 chk("R6 byte kept", {24'd0, tx_byte}, 32'h5A);
    chk("R6 still valid", {31'd0, tx_valid}, 1);
    accept();
    #1 chk("R6 released", {31'd0, tx_valid}, 0);

    // R7 overrun
    push(8'h11);
    push(8'h22);
    rd(RXS, d); chk("R7 overrun flagged", d, 3);
    rd(RXS, d); chk("R7 overrun cleared by read", d, 1);
    rd(RXD, d); chk("R7 first byte kept", d, 32'h11);
    rd(RXS, d); chk("R7 empty", d, 0);

    // R8 arrival in the same cycle as data read
    push(8'h33);
    @(negedge clk);
    bus_addr = RXD; bus_rd = 1'b1; rx_valid = 1'b1; rx_byte = 8'h44;
    #1 chk("R8 old byte returned", bus_rdata, 32'h33);
    @(posedge clk); #0.5;
    bus_rd = 1'b0; rx_valid = 1'b0;
    rd(RXS, d); chk("R8 full, no overrun", d, 1);
    rd(RXD, d); chk("R8 new byte held", d, 32'h44);

    // R9 write coinciding with accept
    wr(TXD, 32'h66);
    @(negedge clk);
    bus_addr = TXD; bus_wdata = 32'h77; bus_wr = 1'b1; tx_ready = 1'b1;
    @(posedge clk); #0.5;
    bus_wr = 1'b0; tx_ready = 1'b0;
    #1 chk("R9 valid kept", {31'd0, tx_valid}, 1);
    chk("R9 new byte", {24'd0, tx_byte}, 32'h77);
    accept();

    // R10 ignored accesses
    wr(RXS, 32'hFFFF_FFFF);
    rd(RXS, d); chk("R10 rx status write", d, 0);
    wr(TXS, 32'hFFFF_FFFF);
    rd(TXS, d); chk("R10 tx status write", d, 1);
    wr(32'hFFFE_000C, 32'h12);
    wr(32'hFFFF_000D, 32'h13);
    wr(32'hFFFF_001C, 32'h14);
    #1 chk("R10 undecoded writes", {31'd0, tx_valid}, 0);
    push(8'h55);
    rd(32'hFFFF_0014, d); chk("R10 outside read zero", d, 0);
    rd(32'hFFFF_0005, d); chk("R10 misaligned read zero", d, 0);
    rd(TXD, d); chk("R10 tx data reads zero", d, 0);
    rd(RXS, d); chk("R10 rx unaffected", d, 1);
    rd(RXD, d); chk("R10 rx byte intact", d, 32'h55);

    summary();
  end
endmodule